// File: doc/BRIEF.md
# Mode-Register-Driven Asynchronous Frame Transmitter

This block turns one character into an asynchronous serial frame on a single transmit line. The frame layout is chosen at run time by an 8-bit mode word: character length, number of stop bits, whether a parity bit is sent and which sense it has, and whether the line is inverted. A baud tick supplied from outside sets the pace. Each frame bit lasts exactly one tick interval.

Software or a controller presents a data word and pulses `load`. If the transmitter is enabled, the mode word selects a UART format and no frame is in progress, the block takes a snapshot of the data and the mode word and raises `busy`. It waits for the next baud tick and then shifts out the start bit, the data bits LSB first, the optional parity bit and the stop bits, one per tick. When the mode field is cleared to "disabled", the line returns to idle at once, even in the middle of a frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `busy` and `ready` are 0. With `mode_reg` = 00h, `txd` is 1.
- R2: `mode_reg[2:0]` selects the format: 100 gives 7 data bits, 101 gives 8 and 110 gives 9. Any other code starts no frame, keeps `ready` at 0 and leaves `load` without effect. `mode_reg[3]` has no effect.
- R3: A frame is a start bit of 0, then the data bits LSB first, then the parity bit if one is enabled, then the stop bits at 1. The start bit appears on the first baud tick after the load is accepted. Each later tick moves to the next bit, and no bit changes between ticks.
- R4: When `mode_reg[4]` is 0 the frame has one stop bit. When it is 1 the frame has two.
- R5: When `mode_reg[6]` is 1, a parity bit follows the data. With `mode_reg[5]` at 0 it makes the count of ones in data plus parity odd, and with `mode_reg[5]` at 1 it makes that count even. While `mode_reg[6]` is 0, no parity bit is sent and `mode_reg[5]` has no effect.
- R6: When `mode_reg[7]` is 1 the line is inverted, and this includes the idle level, which becomes 0.
- R7: While `tx_en` is 0, `load` is ignored and `ready` is 0.
- R8: A `load` that arrives while `busy` is 1 is ignored and does not alter the frame in progress.
- R9: The data and the mode word are captured when the load is accepted. Later changes to `mode_reg` with a nonzero mode field, and later changes to `tx_data`, do not affect the frame.
- R10: If `mode_reg[2:0]` becomes 000 during a frame, `busy` is 0 on the next cycle and `txd` returns to the idle level.
- R11: `busy` rises in the cycle after an accepted load and falls after the baud tick that ends the last stop bit. `ready` is 1 exactly when `tx_en` is 1, the mode field is a UART code and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_reg | input | 8 | Frame-format mode word |
| tx_en | input | 1 | Transmit enable |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_data | input | 9 | Character to send, LSB first |
| load | input | 1 | Start-of-frame request strobe |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A frame is pending or in progress |
| ready | output | 1 | A load would be accepted now |

## Verification
An accepted load shows up as `busy` one clock later. Until the first tick, the line stays at the idle level. Each bit value is visible one clock after the edge that consumes its baud tick, and `busy` drops one clock after the tick that ends the final stop bit. An abort through a zero mode field takes effect one clock after the field changes. The bench drives `load`, `baud_tick` and `mode_reg` on falling edges and reads outputs on the next falling edge, so every sample lands after exactly one register update. Idle cycles are placed between ticks so that the line can be checked for stability between bits.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_MAX = 9,
  parameter int STOP_MAX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          mode_reg,
  input  logic                tx_en,
  input  logic                baud_tick,
  input  logic [DATA_MAX-1:0] tx_data,
  input  logic                load,
  output logic                txd,
  output logic                busy,
  output logic                ready
);
  localparam int FRAME_W = DATA_MAX + STOP_MAX + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0]  shreg;
  logic [CNT_W-1:0]    cnt;
  logic                inv_q;
  logic [3:0]          len;
  logic [DATA_MAX-1:0] dmask;
  logic                par_bit;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    cnt_init;
  logic                uart_ok;
  logic                mode_off;

  always_comb begin
    case (mode_reg[2:0])
      3'b100:  len = 4'd7;
      3'b101:  len = 4'd8;
      3'b110:  len = 4'd9;
      default: len = 4'd0;
    endcase
  end

  assign uart_ok  = (len != 4'd0);
  assign mode_off = (mode_reg[2:0] == 3'b000);

  always_comb begin
    for (int i = 0; i < DATA_MAX; i++)
      dmask[i] = (i < int'(len)) ? tx_data[i] : 1'b0;
  end

  assign par_bit = mode_reg[5] ? (^dmask) : ~(^dmask);

  always_comb begin
    frame    = '1;
    frame[1] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(len)) frame[i+2] = dmask[i];
    for (int j = 0; j < FRAME_W; j++)
      if (mode_reg[6] && (j == int'(len) + 2)) frame[j] = par_bit;
  end

  assign cnt_init = CNT_W'(len) + CNT_W'(mode_reg[6]) + CNT_W'(mode_reg[4]) + CNT_W'(3);

  assign busy  = (cnt != '0);
  assign ready = tx_en && uart_ok && !busy;
  assign txd   = busy ? (shreg[0] ^ inv_q) : ~mode_reg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '1;
      inv_q <= 1'b0;
    end else if (busy && mode_off) begin
      cnt   <= '0;
      shreg <= '1;
    end else if (!busy && load && tx_en && uart_ok) begin
      shreg <= frame;
      cnt   <= cnt_init;
      inv_q <= mode_reg[7];
    end else if (busy && baud_tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      cnt   <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_reg,
  input logic       tx_en,
  input logic       baud_tick,
  input logic       load,
  input logic       txd,
  input logic       busy
);
  assert_start_needs_valid_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load && tx_en && (mode_reg[2] && !(mode_reg[1] && mode_reg[0]))));

  assert_disabled_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[2:0] == 3'b000) |=> !busy);

  assert_line_holds_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd));

  assert_busy_ends_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(baud_tick) || $past(mode_reg[2:0] == 3'b000)));

  assert_no_start_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .tx_en(tx_en),
  .baud_tick(baud_tick), .load(load), .txd(txd), .busy(busy)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode_reg = 8'h00;
  logic       tx_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic [8:0] tx_data = '0;
  logic       load = 1'b0;
  logic       txd, busy, ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .tx_en(tx_en),
    .baud_tick(baud_tick), .tx_data(tx_data), .load(load),
    .txd(txd), .busy(busy), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic pulse_load(input logic [8:0] d);
    tx_data = d;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // disturb: 0 none, 1 extra load mid-frame (R8), 2 mode/data change mid-frame (R9)
  task automatic run_frame(input logic [7:0] m, input logic [8:0] d, input int disturb, input string req);
    int len, n, ones;
    logic exp_bits[16];
    logic inv, par;
    len = (m[2:0] == 3'b100) ? 7 : (m[2:0] == 3'b101) ? 8 : 9;
    inv = m[7];
    n = 0;
    exp_bits[n++] = 1'b0;
    ones = 0;
    for (int i = 0; i < len; i++) begin
      exp_bits[n++] = d[i];
      ones += d[i];
    end
    if (m[6]) begin
      par = m[5] ? logic'(ones % 2) : logic'(1 - ones % 2);
      exp_bits[n++] = par;
    end
    exp_bits[n++] = 1'b1;
    if (m[4]) exp_bits[n++] = 1'b1;
    @(negedge clk);
    mode_reg = m;
    tx_en = 1'b1;
    @(negedge clk);
    check({req, " ready before load R11"}, ready, 1);
    pulse_load(d);
    check({req, " busy after load R11"}, busy, 1);
    check({req, " idle before first tick R3"}, txd, 1 ^ inv);
    @(negedge clk);
    check({req, " no bit without tick R3"}, txd, 1 ^ inv);
    for (int i = 0; i < n; i++) begin
      do_tick();
      check({req, " frame bit R3"}, txd, exp_bits[i] ^ inv);
      check({req, " busy mid-frame R11"}, busy, 1);
      if (i == 3 && disturb == 1) pulse_load(~d);
      else if (i == 3 && disturb == 2) begin
        mode_reg = m ^ 8'hF1;
        tx_data = ~d;
        @(negedge clk);
      end else @(negedge clk);
      check({req, " stable between ticks R3"}, txd, exp_bits[i] ^ inv);
    end
    do_tick();
    check({req, " busy clears after last stop R11"}, busy, 0);
    mode_reg = m;
    @(negedge clk);
    check({req, " idle after frame R6"}, txd, 1 ^ inv);
  endtask

  task automatic test_reset();
    check("reset busy R1", busy, 0);
    check("reset ready R1", ready, 0);
    check("reset txd R1", txd, 1);
  endtask

  task automatic test_refused(input logic [7:0] m, input logic en, input string req);
    @(negedge clk);
    mode_reg = m;
    tx_en = en;
    @(negedge clk);
    check({req, " ready low"}, ready, 0);
    pulse_load(9'h0A5);
    check({req, " busy stays low"}, busy, 0);
    do_tick();
    check({req, " line idle"}, txd, 1 ^ m[7]);
    check({req, " still not busy"}, busy, 0);
  endtask

  task automatic test_abort();
    @(negedge clk);
    mode_reg = 8'h05 | 8'h80;
    tx_en = 1'b1;
    @(negedge clk);
    pulse_load(9'h000);
    do_tick();
    check("abort start bit R10", txd, 1);
    @(negedge clk);
    mode_reg = 8'h80;
    @(negedge clk);
    check("abort busy low R10", busy, 0);
    check("abort line idle R10", txd, 0);
    mode_reg = 8'h00;
    @(negedge clk);
    check("abort idle after polarity change R6", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    test_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_frame(8'h04, 9'h05A, 0, "7-bit 1 stop R2 R4");
    run_frame(8'h75, 9'h0C3, 0, "8-bit even parity 2 stop R5 R4");
    run_frame(8'h46, 9'h101, 0, "9-bit odd parity R5 R2");
    run_frame(8'h45, 9'h007, 0, "8-bit odd parity R5");
    run_frame(8'h25, 9'h0F1, 0, "parity sense ignored R5");
    run_frame(8'hC5, 9'h096, 0, "inverted line R6");
    run_frame(8'h0D, 9'h033, 0, "clock-select bit ignored R2");
    run_frame(8'h55, 9'h1AB, 1, "load while busy R8");
    run_frame(8'h74, 9'h03C, 2, "mode captured at load R9");
    test_refused(8'h00, 1'b1, "disabled mode R2");
    test_refused(8'h03, 1'b1, "non-UART code R2");
    test_refused(8'h87, 1'b1, "reserved code inverted R2 R6");
    test_refused(8'h05, 1'b0, "enable low R7");
    test_abort();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule